// File: doc/BRIEF.md
# Shadow Memory Region Attribute Controller

This block sits on the CPU memory path in front of the upper-memory window from 0xC0000 to 0xFFFFF. It keeps one 4-bit attribute field for each segment of that window in two 32-bit attribute words. For every access it decides whether a read is served from shadow RAM or from the boot ROM, and whether a write reaches shadow RAM or is dropped. It also produces the array offset of the access. The window has twelve 16 KB segments from 0xC0000 to 0xEFFFF and one 64 KB segment from 0xF0000 to 0xFFFFF.

The attribute words are loaded through a plain configuration write port. Each byte lane of a write is enabled separately, so firmware can change the attributes of two segments without touching the others. Accesses arrive on a valid/ready request channel. The decision leaves through one register stage on a valid/ready result channel. A request is accepted while the stage is empty or the result is being taken in the same cycle (`acc_ready = !out_valid || out_ready`). A stalled result holds every output field until it is taken. Each accepted request produces exactly one result, and results leave in order.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset no result is pending, `acc_ready` is 1, and every segment has attribute 0: reads go to ROM and writes are dropped.
- R2: An address A with 0xC0000 <= A <= 0xEFFFF lies in segment (A-0xC0000)/0x4000, numbered 0 to 11. Any address from 0xF0000 to 0xFFFFF lies in segment 12.
- R3: Field positions. Word 0 (`cfg_sel`=0): bits 15:12 belong to segment 12, and bits 19:16, 23:20, 27:24 and 31:28 belong to segments 0 to 3. Word 1 (`cfg_sel`=1): bits 4k+3:4k belong to segment 4+k, for k = 0 to 7.
- R4: A read inside the window asserts `out_ram_rd` when bit 0 of its segment's field is 1, and `out_rom_rd` when that bit is 0. Exactly one of the two is set.
- R5: A write inside the window gives `out_ram_wstrb` = `acc_be` when bit 1 of its segment's field is 1. When that bit is 0, `out_ram_wstrb` is 0.
- R6: A configuration write changes byte j (bits 8j+7:8j) of the selected word only when `cfg_be[j]` is 1. With `cfg_be` = 0 no attribute changes.
- R7: Inside the window `out_offset` = A - 0xC0000, and `out_hit` is 1. Outside the window `out_offset` is 0.
- R8: An address below 0xC0000 gives `out_hit` = 0, `out_ram_rd` = 0, `out_rom_rd` = 0 and `out_ram_wstrb` = 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `acc_ready` is 0 and all result fields hold their values.
- R10: An access is decoded with the attributes in force before the clock edge that accepts it. A configuration write on that same edge affects only later accesses.
- R11: A read never asserts `out_ram_wstrb`. A write never asserts `out_ram_rd` or `out_rom_rd`. `out_write` echoes the access direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Attribute word write strobe |
| cfg_sel | input | 1 | Attribute word select (0 or 1) |
| cfg_wdata | input | 32 | Attribute write data |
| cfg_be | input | 4 | Byte lane enables of the attribute write |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted this cycle |
| acc_addr | input | 20 | Access byte address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_be | input | 4 | Access byte enables |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_hit | output | 1 | Address inside the managed window |
| out_write | output | 1 | Direction of the decided access |
| out_ram_rd | output | 1 | Read served by shadow RAM |
| out_rom_rd | output | 1 | Read served by boot ROM |
| out_ram_wstrb | output | 4 | Shadow RAM byte write strobes |
| out_offset | output | 20 | Array offset of the access |

## Verification
The hardest case to reach from the ports is one where the same clock edge accepts an access and rewrites that access's segment attribute. Both channels must be driven in one cycle, and the old and new field values must steer the access differently. The bench drives both inputs at one falling edge. It first checks that this access still follows the old field, then checks that the next access follows the new one. The stall path also takes a deliberate sequence: the consumer is blocked while a second request waits behind a held result, and each stalled cycle is checked. The field-to-segment mapping is swept with sixteen attribute patterns. Each pattern has its own byte-lane enables, and each is probed at the first, middle and last address of all thirteen segments.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned DEF_ADDR_W    = 20;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_BASE      = 'hC0000;
  localparam int unsigned DEF_SEG_SHIFT = 14;
  localparam int unsigned DEF_N_SMALL   = 12;

  // decoded per-segment attribute
  typedef struct packed {
    logic wr_ram;  // writes reach shadow RAM
    logic rd_ram;  // reads served from shadow RAM
  } seg_attr_t;
endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_REG  = 2,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [NB-1:0]           cfg_be,
  output logic [N_REG*DATA_W-1:0] regs_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_flat <= '0;
    end else if (cfg_we) begin
      for (int r = 0; r < N_REG; r++) begin
        for (int b = 0; b < NB; b++) begin
          if (cfg_sel == SEL_W'(r) && cfg_be[b])
            regs_flat[r*DATA_W + 8*b +: 8] <= cfg_wdata[8*b +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BASE      = 'hC0000,
  parameter int unsigned SEG_SHIFT = 14,
  parameter int unsigned N_SMALL   = 12,
  localparam int unsigned IDX_W    = $clog2(N_SMALL + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  seg,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] raw;

  assign hit    = addr >= ADDR_W'(BASE);
  assign diff   = addr - ADDR_W'(BASE);
  assign raw    = diff >> SEG_SHIFT;
  assign offset = hit ? diff : '0;

  always_comb begin
    if (!hit)                         seg = '0;
    else if (raw >= ADDR_W'(N_SMALL)) seg = IDX_W'(N_SMALL);
    else                              seg = raw[IDX_W-1:0];
  end
endmodule

// File: rtl/shadow_attr_select.sv
module shadow_attr_select
  import shadow_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_SMALL  = 12,
  parameter int unsigned LOW_CNT  = 4,   // small segments held in word 0
  parameter int unsigned LOW_BASE = 16,  // bit of word 0 holding segment 0
  parameter int unsigned TOP_POS  = 12,  // bit of word 0 holding top segment
  localparam int unsigned IDX_W   = $clog2(N_SMALL + 1),
  localparam int unsigned N_SLOT  = 2 ** IDX_W
) (
  input  logic [2*DATA_W-1:0] regs_flat,
  input  logic [IDX_W-1:0]    seg,
  output seg_attr_t           attr
);
  logic [3:0] nib [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    if (g == N_SMALL) begin : g_top
      assign nib[g] = regs_flat[TOP_POS +: 4];
    end else if (g < LOW_CNT) begin : g_low
      assign nib[g] = regs_flat[LOW_BASE + 4*g +: 4];
    end else if (g < N_SMALL) begin : g_high
      assign nib[g] = regs_flat[DATA_W + 4*(g - LOW_CNT) +: 4];
    end else begin : g_unused
      assign nib[g] = 4'h0;
    end
  end

  logic [3:0] sel_nib;
  assign sel_nib     = nib[seg];
  assign attr.rd_ram = sel_nib[0];
  assign attr.wr_ram = sel_nib[1];
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned BASE      = DEF_BASE,
  parameter int unsigned SEG_SHIFT = DEF_SEG_SHIFT,
  parameter int unsigned N_SMALL   = DEF_N_SMALL,
  localparam int unsigned NB       = DATA_W / 8,
  localparam int unsigned IDX_W    = $clog2(N_SMALL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NB-1:0]     cfg_be,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [NB-1:0]     acc_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_write,
  output logic              out_ram_rd,
  output logic              out_rom_rd,
  output logic [NB-1:0]     out_ram_wstrb,
  output logic [ADDR_W-1:0] out_offset
);
  typedef struct packed {
    logic              hit;
    logic              write;
    logic              ram_rd;
    logic              rom_rd;
    logic [NB-1:0]     wstrb;
    logic [ADDR_W-1:0] offset;
  } decision_t;

  logic [2*DATA_W-1:0] regs_flat;
  logic                hit;
  logic [IDX_W-1:0]    seg;
  logic [ADDR_W-1:0]   offset;
  seg_attr_t           attr;
  decision_t           dec_d, dec_q;
  logic                st_valid;

  shadow_attr_regs #(.DATA_W(DATA_W), .N_REG(2)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_be, .regs_flat
  );

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .SEG_SHIFT(SEG_SHIFT), .N_SMALL(N_SMALL)
  ) u_dec (
    .addr(acc_addr), .hit, .seg, .offset
  );

  shadow_attr_select #(.DATA_W(DATA_W), .N_SMALL(N_SMALL)) u_sel (
    .regs_flat, .seg, .attr
  );

  always_comb begin
    dec_d.hit    = hit;
    dec_d.write  = acc_write;
    dec_d.ram_rd = hit && !acc_write && attr.rd_ram;
    dec_d.rom_rd = hit && !acc_write && !attr.rd_ram;
    dec_d.wstrb  = (hit && acc_write && attr.wr_ram) ? acc_be : '0;
    dec_d.offset = offset;
  end

  assign acc_ready = !st_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      dec_q    <= '0;
    end else if (acc_ready) begin
      st_valid <= acc_valid;
      if (acc_valid) dec_q <= dec_d;
    end
  end

  assign out_valid     = st_valid;
  assign out_hit       = dec_q.hit;
  assign out_write     = dec_q.write;
  assign out_ram_rd    = dec_q.ram_rd;
  assign out_rom_rd    = dec_q.rom_rd;
  assign out_ram_wstrb = dec_q.wstrb;
  assign out_offset    = dec_q.offset;
endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk #(
  parameter int unsigned NB     = 4,
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic              out_write,
  input logic              out_ram_rd,
  input logic              out_rom_rd,
  input logic [NB-1:0]     out_ram_wstrb,
  input logic [ADDR_W-1:0] out_offset
);
  AST_RD_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit && !out_write |-> (out_ram_rd ^ out_rom_rd)); // R4

  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_write |-> out_ram_wstrb == '0); // R11

  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write |-> !out_ram_rd && !out_rom_rd); // R11

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> !out_ram_rd && !out_rom_rd && out_ram_wstrb == '0); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !acc_ready); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_write)
      && $stable(out_ram_rd) && $stable(out_rom_rd) && $stable(out_ram_wstrb)
      && $stable(out_offset)); // R9
endmodule

bind shadow_attr_ctrl shadow_attr_chk #(.NB(NB), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ready(acc_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_hit(out_hit), .out_write(out_write),
  .out_ram_rd(out_ram_rd), .out_rom_rd(out_rom_rd),
  .out_ram_wstrb(out_ram_wstrb), .out_offset(out_offset)
);

// File: tb/sim_shadow_attr_ctrl.sv
module sim_shadow_attr_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic        acc_ready;
  logic [19:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic        out_valid, out_ready = 1'b1;
  logic        out_hit, out_write, out_ram_rd, out_rom_rd;
  logic [3:0]  out_ram_wstrb;
  logic [19:0] out_offset;

  int checks = 0, fails = 0;
  logic [31:0] mreg [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_ctrl u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2: segment number from address; -1 outside window
  function automatic int seg_of(input logic [19:0] a);
    if (a < 20'hC0000) return -1;
    if ((a - 20'hC0000) / 'h4000 > 12) return 12;
    return int'((a - 20'hC0000) / 'h4000);
  endfunction

  // R3: field of a segment in the model words
  function automatic logic [3:0] field_of(input int s);
    if (s == 12) return mreg[0][15:12];
    if (s < 4)   return mreg[0][16 + 4*s +: 4];
    return mreg[1][4*(s-4) +: 4];
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int b = 0; b < 4; b++) if (be[b]) mreg[sel][8*b +: 8] = d[8*b +: 8]; // R6
  endtask

  task automatic expect_out(input string req, input logic [19:0] a, input logic w, input logic [3:0] be);
    int s; logic [3:0] f; logic hit;
    s = seg_of(a);
    hit = (s >= 0);
    f = hit ? field_of(s) : 4'h0;
    chk(req, "valid",  out_valid, 1'b1);
    chk(req, "hit",    out_hit, hit);
    chk(req, "write",  out_write, w);
    chk(req, "ram_rd", out_ram_rd, hit && !w && f[0]);
    chk(req, "rom_rd", out_rom_rd, hit && !w && !f[0]);
    chk(req, "wstrb",  out_ram_wstrb, (hit && w && f[1]) ? be : 4'h0);
    chk(req, "offset", out_offset, hit ? a - 20'hC0000 : 20'h0);
  endtask

  task automatic access(input string req, input logic [19:0] a, input logic w, input logic [3:0] be);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_be = be; out_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    expect_out(req, a, w, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mreg[0] = '0; mreg[1] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 1'b0);
    chk("R1", "acc_ready after reset", acc_ready, 1'b1);
    for (int s = 0; s < 13; s++) begin
      logic [19:0] a;
      a = (s < 12) ? 20'(20'hC0000 + s*'h4000) : 20'hF0000;
      access("R1", a, 1'b0, 4'hF);
      access("R1", a + 20'h10, 1'b1, 4'hF);
    end

    // R2 R3 R4 R5 R6 R7 R11: sweep of attribute patterns and segment edges
    for (int p = 0; p < 16; p++) begin
      logic [31:0] w0, w1;
      for (int n = 0; n < 8; n++) begin
        w0[4*n +: 4] = 4'((n + 5*p) % 16);
        w1[4*n +: 4] = 4'((3*n + 7*p + 1) % 16);
      end
      cfg_write(1'b0, w0, 4'(p));
      cfg_write(1'b1, w1, 4'(~p));
      for (int s = 0; s < 13; s++) begin
        logic [19:0] lo, hi;
        lo = (s < 12) ? 20'(20'hC0000 + s*'h4000) : 20'hF0000;
        hi = (s < 12) ? lo + 20'h3FFF : 20'hFFFFF;
        access("R2/R3/R4/R7", lo, 1'b0, 4'hF);
        access("R2/R3/R4/R7", hi, 1'b0, 4'hF);
        access("R3/R5/R6/R11", lo + ((hi - lo) >> 1), 1'b1, 4'((s + p) % 16));
      end
    end

    // R6: all lanes disabled leaves attributes unchanged
    cfg_write(1'b1, 32'h3333_3333, 4'hF);
    cfg_write(1'b1, 32'h0000_0000, 4'h0);
    access("R6", 20'hD4000, 1'b0, 4'hF);
    chk("R6", "ram_rd after be=0 write", out_ram_rd, 1'b1);
    access("R6", 20'hEC000, 1'b1, 4'h5);
    chk("R6", "wstrb after be=0 write", out_ram_wstrb, 4'h5);

    // R8: addresses below the window
    access("R8", 20'h00000, 1'b0, 4'hF);
    access("R8", 20'hBFFFF, 1'b1, 4'hF);
    access("R8", 20'h7C000, 1'b0, 4'hF);
    access("R8", 20'h12345, 1'b1, 4'h3);

    // R10: config write and access accepted on the same edge
    cfg_write(1'b1, 32'h0000_0000, 4'hF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h1111_1111; cfg_be = 4'hF;
    acc_valid = 1'b1; acc_addr = 20'hD0000; acc_write = 1'b0; acc_be = 4'hF;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R10", "rom_rd uses old field", out_rom_rd, 1'b1);
    chk("R10", "ram_rd uses old field", out_ram_rd, 1'b0);
    mreg[1] = 32'h1111_1111;
    access("R10", 20'hD0000, 1'b0, 4'hF);
    chk("R10", "ram_rd uses new field", out_ram_rd, 1'b1);

    // R9: back-pressure
    cfg_write(1'b0, 32'h0003_0000, 4'hF);
    cfg_write(1'b1, 32'h0030_0000, 4'hF);
    @(negedge clk);
    out_ready = 1'b0;
    acc_valid = 1'b1; acc_addr = 20'hC0040; acc_write = 1'b0; acc_be = 4'hF;
    @(negedge clk);
    acc_addr = 20'hE4008; acc_write = 1'b1; acc_be = 4'h9;
    for (int k = 0; k < 4; k++) begin
      chk("R9", "acc_ready while stalled", acc_ready, 1'b0);
      expect_out("R9", 20'hC0040, 1'b0, 4'hF);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    chk("R9", "acc_ready when drained", acc_ready, 1'b1);
    @(negedge clk);
    acc_valid = 1'b0;
    expect_out("R9", 20'hE4008, 1'b1, 4'h9);
    chk("R9", "second access wstrb", out_ram_wstrb, 4'h9);
    @(negedge clk);
    chk("R9", "drained", out_valid, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule